// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache Controller

This block sits between a processor read port and a slower word-wide main memory covering a 64K-word space. It holds 8 sets, and each set has two ways of one 8-word block. A read is accepted while `cpu_ready` is high. The address is split into tag, set index and word offset. The tag is compared against both ways of the indexed set. A hit returns the stored word on the next cycle.

On a miss the controller picks a victim way. An invalid way is used first; otherwise the way not most recently used in that set is replaced. It then pulses a block request to memory and writes the eight returned words into the victim way. The `lt_mode` input is sampled when the request is accepted and chooses how the word reaches the processor. With forwarding on, the requested word is handed over in the cycle it is written into the cache. With forwarding off, the processor waits until the whole block is in place, and the word is then read out of the cache in one extra cycle.

Top module: `cache2w_ctrl`

## Requirements
- R1: The address is decoded as tag = `cpu_addr[15:6]`, set = `cpu_addr[5:3]`, word = `cpu_addr[2:0]`. A miss drives `mem_addr` = {tag, set, 3'b000}.
- R2: During and after reset `cpu_ready`=1, `cpu_rvalid`=0 and `mem_req`=0. All ways are invalid, so the first read of any block misses.
- R3: A read accepted (`cpu_req` and `cpu_ready` high at a clock edge) that hits raises `cpu_rvalid` in the next cycle, with the stored word. No memory request is made.
- R4: A read that misses raises `mem_req` for exactly one cycle, in the cycle after acceptance. `cpu_ready` stays low until the fill ends. Words arriving with `mem_rvalid` are taken as offsets 0 to 7 in ascending order.
- R5: On a miss, an invalid way is filled before any valid way is evicted. Way 0 is chosen when both ways are invalid.
- R6: When both ways are valid, the way replaced is the one not used by the latest hit or fill in that set.
- R7: With forwarding off, `cpu_rvalid` rises one cycle after the cycle following the arrival of word 7. The data is read back from the cache.
- R8: With forwarding on, `cpu_rvalid` rises in the cycle after the requested word arrives, carrying that memory word. `cpu_ready` returns in the cycle after word 7 arrives.
- R9: Every accepted read produces exactly one `cpu_rvalid` pulse.
- R10: `lt_mode` is used only at acceptance. Changing it during a fill has no effect on that read.
- R11: `cpu_req` is ignored while `cpu_ready` is low. It starts no extra memory request and no extra delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Read request |
| cpu_addr | input | 16 | Read word address |
| lt_mode | input | 1 | 1 = forward words during fill, 0 = deliver after fill |
| cpu_ready | output | 1 | Controller can accept a read |
| cpu_rvalid | output | 1 | One-cycle data strobe |
| cpu_rdata | output | 16 | Read data |
| mem_req | output | 1 | One-cycle block fetch request |
| mem_addr | output | 16 | Block base address (offset 0) |
| mem_rvalid | input | 1 | Memory word strobe |
| mem_rdata | input | 16 | Memory word |

## Verification
The hardest case to reach from the ports is a replacement decision in a set whose two ways are both valid and whose LRU bit was last set by a hit rather than a fill. Only that case separates true LRU from a fill-order policy. The stimulus gets there with a directed sequence of three blocks sharing set 0, interleaving hits and misses. This is followed by a repeated sweep over 160 consecutive words, where sets 0 to 3 thrash among three blocks. Random reads then use only four tags, so that sets often hold two valid blocks. During these reads the forwarding input and the request line are toggled in the middle of fills.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2
  } cache_st_e;
endpackage

// File: rtl/cache2w_tagdir.sv
module cache2w_tagdir #(
  parameter int TAG_W = 10,
  parameter int SET_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             hit,
  output logic             hit_way,
  output logic             victim_way,
  input  logic             lru_we,
  input  logic [SET_W-1:0] lru_set,
  input  logic             lru_way,
  input  logic             fill_we,
  input  logic [SET_W-1:0] fill_set,
  input  logic             fill_way,
  input  logic [TAG_W-1:0] fill_tag
);
  localparam int NSETS = 1 << SET_W;

  logic [NSETS-1:0][1:0]            valid_q, valid_d;
  logic [NSETS-1:0][1:0][TAG_W-1:0] tag_q, tag_d;
  logic [NSETS-1:0]                 lru_q, lru_d;
  logic                             m0, m1;

  // lookup and victim choice
  assign m0 = valid_q[rd_set][0] && (tag_q[rd_set][0] == rd_tag);
  assign m1 = valid_q[rd_set][1] && (tag_q[rd_set][1] == rd_tag);
  assign hit = m0 | m1;
  assign hit_way = m1;

  always_comb begin
    if (!valid_q[rd_set][0])      victim_way = 1'b0;
    else if (!valid_q[rd_set][1]) victim_way = 1'b1;
    else                          victim_way = lru_q[rd_set];
  end

  // next state
  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    lru_d   = lru_q;
    if (fill_we) begin
      valid_d[fill_set][fill_way] = 1'b1;
      tag_d[fill_set][fill_way]   = fill_tag;
    end
    if (lru_we) lru_d[lru_set] = ~lru_way;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
      lru_q   <= '0;
    end else begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      lru_q   <= lru_d;
    end
  end

  // R5: a valid way is never picked while the set still has an invalid one
  assert_victim_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q[rd_set][0] && valid_q[rd_set][1]) |-> !valid_q[rd_set][victim_way]);

  // R6: after a use the set points away from the way just used
  assert_lru_away_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lru_we |=> (lru_q[$past(lru_set)] != $past(lru_way)));

  // R4: a fill never leaves the same block in both ways of a set
  for (genvar g = 0; g < NSETS; g++) begin : g_dup
    assert_no_dup_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_q[g][0] && valid_q[g][1] && (tag_q[g][0] == tag_q[g][1])));
  end
endmodule

// File: rtl/cache2w_dataram.sv
module cache2w_dataram #(
  parameter int DATA_W = 16,
  parameter int SET_W  = 3,
  parameter int OFF_W  = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SET_W-1:0]  wset,
  input  logic              wway,
  input  logic [OFF_W-1:0]  woff,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SET_W-1:0]  rset,
  input  logic              rway,
  input  logic [OFF_W-1:0]  roff,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = SET_W + 1 + OFF_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[{wset, wway, woff}] <= wdata;
  end

  assign rdata = mem_q[{rset, rway, roff}];
endmodule

// File: rtl/cache2w_fsm.sv
module cache2w_fsm
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int SET_W  = 3,
  parameter int OFF_W  = 3,
  localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              lt_mode,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              hit,
  input  logic              hit_way,
  input  logic              victim_way,
  output logic              ram_we,
  output logic [SET_W-1:0]  ram_wset,
  output logic              ram_wway,
  output logic [OFF_W-1:0]  ram_woff,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [SET_W-1:0]  ram_rset,
  output logic              ram_rway,
  output logic [OFF_W-1:0]  ram_roff,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              lru_we,
  output logic [SET_W-1:0]  lru_set,
  output logic              lru_way,
  output logic              fill_we,
  output logic [SET_W-1:0]  fill_set,
  output logic              fill_way,
  output logic [TAG_W-1:0]  fill_tag
);
  localparam logic [OFF_W-1:0] LAST = '1;

  cache_st_e         st_q, st_d;
  logic [SET_W-1:0]  set_q;
  logic [TAG_W-1:0]  tag_q;
  logic [OFF_W-1:0]  off_q, cnt_q, cnt_d;
  logic              way_q, lt_q, rv_q, rv_d, mreq_q, mreq_d, miss_en;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic [SET_W-1:0]  a_set;
  logic [TAG_W-1:0]  a_tag;
  logic [OFF_W-1:0]  a_off;

  assign a_off = cpu_addr[OFF_W-1:0];
  assign a_set = cpu_addr[OFF_W +: SET_W];
  assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  assign miss_en = (st_q == ST_IDLE) && cpu_req && !hit;

  // next state
  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    rv_d     = 1'b0;
    rd_d     = rd_q;
    mreq_d   = 1'b0;
    ram_we   = 1'b0;
    lru_we   = 1'b0;
    lru_set  = a_set;
    lru_way  = hit_way;
    fill_we  = 1'b0;
    ram_rset = a_set;
    ram_rway = hit_way;
    ram_roff = a_off;
    case (st_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (hit) begin
            rv_d   = 1'b1;
            rd_d   = ram_rdata;
            lru_we = 1'b1;
          end else begin
            st_d   = ST_FILL;
            cnt_d  = '0;
            mreq_d = 1'b1;
          end
        end
      end
      ST_FILL: begin
        if (mem_rvalid) begin
          ram_we = 1'b1;
          cnt_d  = cnt_q + 1'b1;
          if (lt_q && (cnt_q == off_q)) begin
            rv_d = 1'b1;
            rd_d = mem_rdata;
          end
          if (cnt_q == LAST) begin
            fill_we = 1'b1;
            lru_we  = 1'b1;
            lru_set = set_q;
            lru_way = way_q;
            st_d    = lt_q ? ST_IDLE : ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        ram_rset = set_q;
        ram_rway = way_q;
        ram_roff = off_q;
        rv_d     = 1'b1;
        rd_d     = ram_rdata;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rv_q   <= 1'b0;
      rd_q   <= '0;
      mreq_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rv_q   <= rv_d;
      rd_q   <= rd_d;
      mreq_q <= mreq_d;
    end
  end

  // miss context, loaded only when a miss is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= '0;
      tag_q <= '0;
      off_q <= '0;
      way_q <= 1'b0;
      lt_q  <= 1'b0;
    end else if (miss_en) begin
      set_q <= a_set;
      tag_q <= a_tag;
      off_q <= a_off;
      way_q <= victim_way;
      lt_q  <= lt_mode;
    end
  end

  assign cpu_ready  = (st_q == ST_IDLE);
  assign cpu_rvalid = rv_q;
  assign cpu_rdata  = rd_q;
  assign mem_req    = mreq_q;
  assign mem_addr   = {tag_q, set_q, {OFF_W{1'b0}}};
  assign ram_wset   = set_q;
  assign ram_wway   = way_q;
  assign ram_woff   = cnt_q;
  assign ram_wdata  = mem_rdata;
  assign fill_set   = set_q;
  assign fill_way   = way_q;
  assign fill_tag   = tag_q;

  // R1: the block address follows the accepted read address
  assert_blk_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr == {$past(cpu_addr[ADDR_W-1:OFF_W]), {OFF_W{1'b0}}}));

  // R4: block request is a single-cycle pulse
  assert_mreq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R4: an accepted miss makes the controller busy
  assert_miss_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready && !hit) |=> (!cpu_ready && mem_req));

  // R3: an accepted hit is answered on the next cycle
  assert_hit_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready && hit) |=> (cpu_rvalid && !mem_req));

  // R8: forwarded word equals the memory word just written
  assert_lt_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL && lt_q && mem_rvalid && cnt_q == off_q)
      |=> (cpu_rvalid && cpu_rdata == $past(mem_rdata)));

  // R7: without forwarding, delivery waits one read-out cycle after word 7
  assert_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL && !lt_q && mem_rvalid && cnt_q == LAST)
      |=> (!cpu_rvalid ##1 cpu_rvalid));
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int SET_W  = 3,
  parameter int OFF_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              lt_mode,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;

  logic              hit, hit_way, victim_way;
  logic              ram_we, ram_wway, ram_rway;
  logic [SET_W-1:0]  ram_wset, ram_rset;
  logic [OFF_W-1:0]  ram_woff, ram_roff;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;
  logic              lru_we, lru_way, fill_we, fill_way;
  logic [SET_W-1:0]  lru_set, fill_set;
  logic [TAG_W-1:0]  fill_tag;

  cache2w_tagdir #(.TAG_W(TAG_W), .SET_W(SET_W)) u_tagdir (
    .clk(clk), .rst_n(rst_n),
    .rd_set(cpu_addr[OFF_W +: SET_W]), .rd_tag(cpu_addr[ADDR_W-1 -: TAG_W]),
    .hit(hit), .hit_way(hit_way), .victim_way(victim_way),
    .lru_we(lru_we), .lru_set(lru_set), .lru_way(lru_way),
    .fill_we(fill_we), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag)
  );

  cache2w_dataram #(.DATA_W(DATA_W), .SET_W(SET_W), .OFF_W(OFF_W)) u_ram (
    .clk(clk), .we(ram_we), .wset(ram_wset), .wway(ram_wway), .woff(ram_woff),
    .wdata(ram_wdata), .rset(ram_rset), .rway(ram_rway), .roff(ram_roff),
    .rdata(ram_rdata)
  );

  cache2w_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_W), .OFF_W(OFF_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .lt_mode(lt_mode),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .hit(hit), .hit_way(hit_way), .victim_way(victim_way),
    .ram_we(ram_we), .ram_wset(ram_wset), .ram_wway(ram_wway), .ram_woff(ram_woff),
    .ram_wdata(ram_wdata), .ram_rset(ram_rset), .ram_rway(ram_rway), .ram_roff(ram_roff),
    .ram_rdata(ram_rdata),
    .lru_we(lru_we), .lru_set(lru_set), .lru_way(lru_way),
    .fill_we(fill_we), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag)
  );

  // R2: idle, silent outputs coming out of reset
  assert_reset_idle_R2: assert property (@(posedge clk)
    $rose(rst_n) |-> (cpu_ready && !cpu_rvalid && !mem_req));

  // R11: a request while busy never starts a memory fetch
  assert_busy_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_ready) |=> !mem_req);
endmodule

// File: tb/cache2w_ctrl_tb.sv
module cache2w_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        lt_mode = 1'b0;
  logic        cpu_ready, cpu_rvalid, mem_req;
  logic [15:0] cpu_rdata, mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mt = 100;
  int mem_reqs = 0;
  logic [15:0] mbase = '0;
  logic [15:0] last_maddr = '0;

  // reference directory
  bit       rv [8][2];
  bit [9:0] rt [8][2];
  bit       rl [8];

  always #2.5 clk = ~clk;

  cache2w_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .lt_mode(lt_mode), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] mem_word(logic [15:0] a);
    logic [15:0] p;
    p = a * 16'd40503;
    return p ^ 16'h3C5A;
  endfunction

  // expected cycles from acceptance edge to the data strobe
  function automatic int exp_lat(bit hit, bit lt, int off);
    if (hit) return 1;
    if (lt) return 4 + off;
    return 12;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // memory model: word k is driven on the (k+2)th falling edge after mem_req
  always @(negedge clk) begin
    if (mem_req) begin
      mbase = mem_addr;
      last_maddr = mem_addr;
      mem_reqs++;
      mt = 0;
    end else if (mt < 100) begin
      mt++;
    end
    if (mt >= 2 && mt <= 9) begin
      mem_rvalid = 1'b1;
      mem_rdata  = mem_word(mbase + 16'(mt - 2));
    end else begin
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_read(logic [15:0] addr, bit lt, bit noise, string tag_msg);
    int s, off, lat, rlat, nrv, m0, way;
    bit hit;
    logic [9:0] tg;
    logic [15:0] rdat;
    s   = int'(addr[5:3]);
    off = int'(addr[2:0]);
    tg  = addr[15:6];
    hit = 1'b0;
    way = 0;
    for (int w = 0; w < 2; w++)
      if (rv[s][w] && rt[s][w] == tg) begin hit = 1'b1; way = w; end
    if (!hit) way = !rv[s][0] ? 0 : (!rv[s][1] ? 1 : int'(rl[s]));

    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_addr = addr; lt_mode = lt;
    m0 = mem_reqs;
    lat = 0; rlat = -1; nrv = 0; rdat = '0;
    @(posedge clk);
    forever begin
      @(negedge clk);
      lat++;
      // R10: flip the mode after acceptance; R11: keep requesting while busy
      lt_mode = 1'($urandom);
      if (noise) cpu_addr = 16'($urandom); else cpu_req = 1'b0;
      if (cpu_rvalid) begin
        nrv++;
        if (rlat < 0) begin rlat = lat; rdat = cpu_rdata; end
      end
      if (cpu_ready) begin cpu_req = 1'b0; break; end
    end
    check(nrv == 1, {"R9 one strobe ", tag_msg}, nrv, 1);
    check(rlat == exp_lat(hit, lt, off),
          hit ? {"R3 hit latency ", tag_msg} : (lt ? {"R8 R10 forward latency ", tag_msg}
                                                   : {"R7 R10 deferred latency ", tag_msg}),
          rlat, exp_lat(hit, lt, off));
    check(rdat == mem_word(addr), {"R3 R7 R8 data ", tag_msg}, int'(rdat), int'(mem_word(addr)));
    check(mem_reqs - m0 == (hit ? 0 : 1), {"R4 R5 R6 R11 fetch count ", tag_msg},
          mem_reqs - m0, hit ? 0 : 1);
    if (!hit)
      check(last_maddr == {addr[15:3], 3'b000}, {"R1 block address ", tag_msg},
            int'(last_maddr), int'({addr[15:3], 3'b000}));
    rv[s][way] = 1'b1;
    rt[s][way] = tg;
    rl[s] = (way == 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < 8; s++) begin
      rl[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin rv[s][w] = 1'b0; rt[s][w] = '0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cpu_ready == 1'b1, "R2 ready in reset", int'(cpu_ready), 1);
    check(cpu_rvalid == 1'b0, "R2 rvalid in reset", int'(cpu_rvalid), 0);
    check(mem_req == 1'b0, "R2 mem_req in reset", int'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_ready == 1'b1, "R2 ready after reset", int'(cpu_ready), 1);

    // directed: three blocks competing for set 0
    do_read(16'h0003, 1'b0, 1'b0, "R2 first miss A");
    do_read(16'h0045, 1'b1, 1'b0, "R5 B into invalid way");
    do_read(16'h0001, 1'b0, 1'b0, "R5 A still hits");
    do_read(16'h0087, 1'b1, 1'b1, "R6 C evicts B");
    do_read(16'h0006, 1'b0, 1'b0, "R6 A hit");
    do_read(16'h0040, 1'b0, 1'b1, "R6 B evicts C");
    do_read(16'h0082, 1'b1, 1'b0, "R6 C evicts A");
    do_read(16'h0000, 1'b1, 1'b0, "R8 first word forward");
    do_read(16'h0047, 1'b1, 1'b0, "R8 last word hit");

    // sequential sweep over 160 words, three passes
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < 160; a++)
        do_read(16'(a), 1'(p), 1'b0, "sweep");

    // random reads over a small tag pool
    for (int i = 0; i < 400; i++) begin
      logic [15:0] ra;
      ra = {8'($urandom % 4), 2'b00, 3'($urandom), 3'($urandom)};
      ra[15:6] = 10'($urandom % 4) * 10'd97;
      do_read(ra, 1'($urandom), 1'($urandom), "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule